// File: doc/BRIEF.md
# Eight-bit addressable latch and demultiplexer

The block holds eight one-bit storage cells behind a three-bit address, one data input and two active-low controls. The controls select one of four modes. Two modes use the address to write one cell or to route the data bit to one output. One mode freezes every cell. One mode forces all outputs low. The block fits wherever a chip needs a small bank of individually settable flags or a 1-of-8 active-high decoder. Typical uses are working bits, a serial-to-parallel holding register, and strobe fan-out.

The design is synchronous. A rising clock edge updates the storage. The addressed output shows the data input combinationally within the same cycle, so the block behaves like a transparent latch as seen from its outputs. A synchronous active-high reset empties every cell.

Top module: `addr_latch8`

## Requirements
- R1: `addr` is an unsigned binary index with bit SEL_W-1 most significant; value k selects cell k and output `dout[k]` (0 selects `dout[0]`, 7 selects `dout[7]`).
- R2: Write mode (`clear_n`=1, `gate_n`=0): `dout[addr]` equals `din` in the same cycle, every other output shows its stored cell, and the rising edge stores `din` into cell `addr` while all other cells keep their values.
- R3: Hold mode (`clear_n`=1, `gate_n`=1): `dout` equals the stored cells, and `din` and `addr` change neither the outputs nor the cells.
- R4: Demultiplex mode (`clear_n`=0, `gate_n`=0): `dout[addr]` equals `din` and every other output is 0.
- R5: Clear mode (`clear_n`=0, `gate_n`=1): all outputs are 0 whatever `din` and `addr` are.
- R6: A rising edge in demultiplex or clear mode sets every cell to 0, which is visible when the block later returns to hold mode.
- R7: A rising edge with `rst` high sets every cell to 0, independent of the mode inputs.
- R8: Successive write-mode edges at different addresses each update exactly their own cell, so a full byte pattern can be built one bit at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset of all cells |
| addr | input | SEL_W | Cell index |
| din | input | 1 | Data bit to write or route |
| gate_n | input | 1 | Active-low enable of the addressed path |
| clear_n | input | 1 | Active-low clear; low empties the cells |
| dout | output | 2**SEL_W | Parallel outputs |

## Verification
The hardest situation to reach is a pattern stored in the cells becoming visible only after a demultiplex or clear phase. Both of those modes hide the cells behind forced-low outputs. The stimulus first builds a distinct byte pattern through write mode. It then sweeps demultiplex or clear across every address and data value, and then returns to hold mode. In hold mode the outputs reveal whether the cells were emptied or retained. Hold mode is also swept across every address and data value to show that neither input reaches the cells.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } latch_mode_e;

    typedef struct packed {
        logic clear_n;
        logic gate_n;
    } latch_ctrl_t;

    function automatic latch_mode_e decode_mode(input latch_ctrl_t c);
        latch_mode_e m;
        case ({c.clear_n, c.gate_n})
            2'b10:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b00:   m = MODE_DEMUX;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

    function automatic logic empties_cells(input latch_mode_e m);
        return (m == MODE_DEMUX) || (m == MODE_CLEAR);
    endfunction

endpackage

// File: rtl/al_addr_dec.sv
module al_addr_dec #(
    parameter int SEL_W = 3,
    localparam int N = 2 ** SEL_W
) (
    input  logic [SEL_W-1:0] addr,
    output logic [N-1:0]     hit
);
    for (genvar i = 0; i < N; i++) begin : g_hit
        assign hit[i] = (addr == SEL_W'(i));
    end
endmodule

// File: rtl/al_store_bank.sv
module al_store_bank
    import addr_latch_pkg::*;
#(
    parameter int N = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  latch_mode_e mode,
    input  logic [N-1:0] hit,
    input  logic        din,
    output logic [N-1:0] cells
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cells[i] <= 1'b0;
            end else if (empties_cells(mode)) begin
                cells[i] <= 1'b0;
            end else if (mode == MODE_WRITE && hit[i]) begin
                cells[i] <= din;
            end
        end
    end

    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=> (((cells & $past(hit)) != '0) == $past(din))); // R2
    AST_UNSEL_KEPT: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_WRITE) |=> (((cells ^ $past(cells)) & ~$past(hit)) == '0)); // R8
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |=> $stable(cells)); // R3
    AST_EMPTY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        empties_cells(mode) |=> (cells == '0)); // R6
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (cells == '0)); // R7
endmodule

// File: rtl/al_out_mux.sv
module al_out_mux
    import addr_latch_pkg::*;
#(
    parameter int N = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  latch_mode_e mode,
    input  logic [N-1:0] hit,
    input  logic        din,
    input  logic [N-1:0] cells,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            unique case (mode)
                MODE_WRITE: dout[i] = hit[i] ? din : cells[i];
                MODE_HOLD:  dout[i] = cells[i];
                MODE_DEMUX: dout[i] = hit[i] & din;
                default:    dout[i] = 1'b0;
            endcase
        end
    end

    AST_DEMUX_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DEMUX) |-> ($onehot0(dout) && ((dout & ~hit) == '0))); // R4
    AST_CLEAR_LOW: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_CLEAR) |-> ($countones(dout) == 0)); // R5
    AST_HOLD_SHOWS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HOLD) |-> (dout == cells)); // R3
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
    import addr_latch_pkg::*;
#(
    parameter int SEL_W = 3,
    localparam int N = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] addr,
    input  logic             din,
    input  logic             gate_n,
    input  logic             clear_n,
    output logic [N-1:0]     dout
);
    latch_ctrl_t ctrl;
    latch_mode_e mode;
    logic [N-1:0] hit;
    logic [N-1:0] cells;

    assign ctrl = '{clear_n: clear_n, gate_n: gate_n};
    assign mode = decode_mode(ctrl);

    al_addr_dec #(.SEL_W(SEL_W)) u_dec (
        .addr (addr),
        .hit  (hit)
    );

    al_store_bank #(.N(N)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .hit   (hit),
        .din   (din),
        .cells (cells)
    );

    al_out_mux #(.N(N)) u_mux (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .hit   (hit),
        .din   (din),
        .cells (cells),
        .dout  (dout)
    );

    AST_ONE_ADDR: assert property (@(posedge clk) disable iff (rst)
        $onehot(hit)); // R1
endmodule

// File: tb/tb_addr_latch8.sv
`timescale 1ns/1ps
module tb_addr_latch8;
    localparam int CYC = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       din = 1'b0;
    logic       gate_n = 1'b1;
    logic       clear_n = 1'b1;
    logic [7:0] dout;

    logic [7:0] model = '0;
    int errors = 0;
    int checks = 0;

    always #(CYC/2) clk = ~clk;

    addr_latch8 dut (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .gate_n(gate_n), .clear_n(clear_n), .dout(dout)
    );

    task automatic check(input logic [7:0] exp, input string tag);
        checks++;
        if (dout !== exp) begin
            errors++;
            $display("FAIL %s: dout=%b expected=%b", tag, dout, exp);
        end
    endtask

    // Drive at negedge, check combinational output, cross one rising edge.
    task automatic step(input logic cn, input logic gn, input logic [2:0] a,
                        input logic d, input string tag);
        logic [7:0] exp;
        @(negedge clk);
        clear_n = cn; gate_n = gn; addr = a; din = d;
        #2;
        case ({cn, gn})
            2'b10: begin exp = model; exp[a] = d; end
            2'b11: exp = model;
            2'b00: begin exp = '0; exp[a] = d; end
            default: exp = '0;
        endcase
        check(exp, tag);
        @(posedge clk);
        case ({cn, gn})
            2'b10: model[a] = d;
            2'b11: ;
            default: model = '0;
        endcase
    endtask

    task automatic fill(input logic [7:0] pat);
        for (int a = 0; a < 8; a++) step(1'b1, 1'b0, 3'(a), pat[a], "R1/R2/R8 write");
    endtask

    initial begin
        #(CYC*100000);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2 check(8'h00, "R7 reset state");

        // R2/R8: build patterns bit by bit, confirm in hold
        fill(8'hA5);
        step(1'b1, 1'b1, 3'd0, 1'b0, "R8 pattern A5 held");
        fill(8'h3C);
        step(1'b1, 1'b1, 3'd5, 1'b1, "R8 pattern 3C held");

        // R3: hold ignores every addr/din combination
        for (int a = 0; a < 8; a++)
            for (int d = 0; d < 2; d++)
                step(1'b1, 1'b1, 3'(a), 1'(d), "R3 hold sweep");

        // R1/R2: overwrite each bit with both values
        for (int a = 0; a < 8; a++) begin
            step(1'b1, 1'b0, 3'(a), 1'b1, "R1 write one");
            step(1'b1, 1'b0, 3'(a), 1'b0, "R1 write zero");
        end

        // R4 then R6: demux sweep after a stored pattern
        fill(8'hFF);
        for (int a = 0; a < 8; a++)
            for (int d = 0; d < 2; d++)
                step(1'b0, 1'b0, 3'(a), 1'(d), "R4 demux sweep");
        step(1'b1, 1'b1, 3'd3, 1'b1, "R6 cells empty after demux");

        // R5 then R6: clear sweep after a stored pattern
        fill(8'h96);
        for (int a = 0; a < 8; a++)
            for (int d = 0; d < 2; d++)
                step(1'b0, 1'b1, 3'(a), 1'(d), "R5 clear sweep");
        step(1'b1, 1'b1, 3'd6, 1'b0, "R6 cells empty after clear");

        // R6: single demux edge empties a full bank
        fill(8'h5A);
        step(1'b0, 1'b0, 3'd2, 1'b1, "R4 single demux");
        step(1'b1, 1'b1, 3'd0, 1'b0, "R6 empty after one demux edge");

        // R7: reset in write mode empties a stored pattern
        fill(8'hC3);
        @(negedge clk);
        rst = 1'b1; clear_n = 1'b1; gate_n = 1'b0; addr = 3'd1; din = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; gate_n = 1'b1;
        model = '0;
        #2 check(8'h00, "R7 reset empties cells");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule